// File: doc/BRIEF.md
# Full-Speed USB Bus State Monitor

This block watches the decoded line state of a full-speed USB bus and turns sustained conditions into events. A single-ended-zero held long enough marks a bus reset. An idle (J) bus held long enough puts the device into suspend. Any K seen while suspended marks a resume. If the device has just finished transmitting and the bus stays idle too long, a response time-out is marked. Each event sets a sticky status bit and raises a one-cycle bus-event pulse for the interrupt controller. Software clears the sticky bits by writing ones.

The block also turns control bits into the drive pins of the transceiver. These drive a remote wake-up K state or a forced SE0, and they pass through the PHY enable and the D+ pull-up enable. A controller-enable input gates all detection. All durations derive from `CYC_PER_US`, the number of clock cycles per microsecond. The reset limit is `(5*CYC_PER_US)/2` cycles (2.5 µs). The suspend limit is `3000*CYC_PER_US` cycles (3 ms). The time-out limit is `(3*CYC_PER_US)/2` cycles (18 bit times at 12 Mb/s). The block has no data stream, so every pin is a plain level or a pulse.

Line encoding on `line_state`: 2'b00 SE0, 2'b01 J (idle), 2'b10 K, 2'b11 illegal (treated as activity, neither idle nor SE0).

Top module: `usbmon_top`

## Requirements
- R1: When SE0 is sampled on more than RST_LIM consecutive cycles, the reset bit (status bit 0) is set. It is visible one cycle after the (RST_LIM+1)th SE0 sample and not before. A detected reset also ends the suspend state, so a later K does not flag resume.
- R2: When J is sampled on more than SUSP_LIM consecutive cycles, the suspend bit (status bit 1) is set and the block enters the suspend state. The bit is visible one cycle after the (SUSP_LIM+1)th J sample.
- R3: While in the suspend state, a sampled K ends suspend and sets the resume bit (status bit 2) two cycles after the K is applied. K outside suspend, SE1, and short SE0 never set resume.
- R4: A one-cycle `tx_done` arms the time-out watch. If J is then sampled on more than TO_LIM consecutive cycles, the time-out bit (status bit 3) is set, one cycle after the (TO_LIM+1)th J sample. Any non-J sample cancels the watch.
- R5: With `force_se0` high, `bus_oe`=1 and both `dp_drv` and `dm_drv` are 0. Otherwise, with `rwake` high, `bus_oe`=1, `dp_drv`=0 and `dm_drv`=1 (K). With both low, `bus_oe`=0.
- R6: Status bits 0..3 are sticky. They stay set until the matching bit of `clr_w1c` is high for a cycle. A clear touches only its own bit, and a set on the same cycle wins.
- R7: `bus_event` is high for exactly one cycle, the same cycle a detection's status bit first appears.
- R8: With `ctrl_en` low, all duration counters are held at zero and nothing is detected. After re-enable, a full duration is needed again.
- R9: Status bit 4 is `phy_en`, bit 5 is `rwake`, bit 7 is `ctrl_en` and bit 8 is `pullup_en`, each one cycle after the input. Bit 6 reads 0. `phy_en_o` and `pullup_o` follow their inputs directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_state | input | 2 | Decoded bus line state |
| tx_done | input | 1 | Pulse: device finished transmitting a packet |
| ctrl_en | input | 1 | Controller enable; gates all detection |
| phy_en | input | 1 | Transceiver enable control bit |
| rwake | input | 1 | Remote wake-up: drive K |
| force_se0 | input | 1 | Force both lines low |
| pullup_en | input | 1 | D+ pull-up enable control bit |
| clr_w1c | input | 4 | Write-one-to-clear for status bits 0..3 |
| status | output | 9 | Status word |
| bus_event | output | 1 | One-cycle event pulse for the interrupt controller |
| bus_oe | output | 1 | Block drives the bus lines |
| dp_drv | output | 1 | Driven D+ value |
| dm_drv | output | 1 | Driven D- value |
| phy_en_o | output | 1 | Transceiver enable |
| pullup_o | output | 1 | D+ pull-up enable |

## Verification
A counter that is off by one shows up at the ports as a status bit that appears one cycle early or late. The bench samples both sides of each duration limit to catch this. A suspend state that is wrong stays hidden until the next K. That K then flags resume where none should occur, or fails to flag one, two cycles after it arrives. A time-out watch that stays armed by mistake is caught the same way: its bit is set after the idle window that should have been cancelled.

// File: rtl/usbmon_pkg.sv
package usbmon_pkg;
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_e;

  localparam int STATUS_W  = 9;
  localparam int NUM_DET   = 4;
  localparam int B_RESET   = 0;
  localparam int B_SUSP    = 1;
  localparam int B_RESUME  = 2;
  localparam int B_TOUT    = 3;
  localparam int B_PHY     = 4;
  localparam int B_RWAKE   = 5;
  localparam int B_CEN     = 7;
  localparam int B_PULL    = 8;
endpackage

// File: rtl/usbmon_dur_det.sv
// Fires a single pulse once cond has been sampled on LIMIT+1 consecutive cycles.
module usbmon_dur_det #(
  parameter int LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cond,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;
  logic          fired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      fired <= 1'b0;
      hit   <= 1'b0;
    end else if (!en || !cond) begin
      cnt   <= '0;
      fired <= 1'b0;
      hit   <= 1'b0;
    end else if (cnt == CW'(LIMIT)) begin
      hit   <= !fired;
      fired <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
      hit <= 1'b0;
    end
  end

  // R7: one detection produces one pulse
  assert_hit_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);

  // R8: a disabled detector never fires
  assert_off_no_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !hit);
endmodule

// File: rtl/usbmon_sticky.sv
module usbmon_sticky #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q,
  output logic         evt
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end

    // R6: a set always lands, even against a clear
    assert_set_sticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q[i]);

    // R7: a newly raised bit comes with the event pulse
    assert_rise_has_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(q[i]) |-> evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt <= 1'b0;
    else        evt <= |set;
  end
endmodule

// File: rtl/usbmon_drv.sv
module usbmon_drv (
  input  logic rwake,
  input  logic force_se0,
  output logic bus_oe,
  output logic dp_drv,
  output logic dm_drv
);
  always_comb begin
    bus_oe = rwake | force_se0;
    dp_drv = 1'b0;
    dm_drv = rwake & ~force_se0;
  end

  always_comb begin
    if (force_se0) begin
      assert_se0_drive_R5: assert (bus_oe && !dp_drv && !dm_drv);
    end
    if (rwake && !force_se0) begin
      assert_k_drive_R5: assert (bus_oe && !dp_drv && dm_drv);
    end
  end
endmodule

// File: rtl/usbmon_top.sv
module usbmon_top
  import usbmon_pkg::*;
#(
  parameter int CYC_PER_US = 48
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] line_state,
  input  logic       tx_done,
  input  logic       ctrl_en,
  input  logic       phy_en,
  input  logic       rwake,
  input  logic       force_se0,
  input  logic       pullup_en,
  input  logic [3:0] clr_w1c,
  output logic [8:0] status,
  output logic       bus_event,
  output logic       bus_oe,
  output logic       dp_drv,
  output logic       dm_drv,
  output logic       phy_en_o,
  output logic       pullup_o
);
  localparam int RST_LIM  = (5 * CYC_PER_US) / 2;
  localparam int SUSP_LIM = 3000 * CYC_PER_US;
  localparam int TO_LIM   = (3 * CYC_PER_US) / 2;

  line_e ls;
  assign ls = line_e'(line_state);

  logic is_j, is_k, is_se0;
  assign is_j   = (ls == LS_J);
  assign is_k   = (ls == LS_K);
  assign is_se0 = (ls == LS_SE0);

  logic rst_hit, susp_hit, to_hit;
  logic res_pulse, suspended, armed;

  usbmon_dur_det #(.LIMIT(RST_LIM)) u_rst (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .cond(is_se0), .hit(rst_hit));

  usbmon_dur_det #(.LIMIT(SUSP_LIM)) u_susp (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .cond(is_j), .hit(susp_hit));

  usbmon_dur_det #(.LIMIT(TO_LIM)) u_tout (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .cond(armed && is_j), .hit(to_hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      suspended <= 1'b0;
      res_pulse <= 1'b0;
      armed     <= 1'b0;
    end else if (!ctrl_en) begin
      suspended <= 1'b0;
      res_pulse <= 1'b0;
      armed     <= 1'b0;
    end else begin
      res_pulse <= suspended && is_k && !rst_hit;
      if (rst_hit)                 suspended <= 1'b0;
      else if (susp_hit)           suspended <= 1'b1;
      else if (suspended && is_k)  suspended <= 1'b0;
      if (tx_done)                 armed <= 1'b1;
      else if (!is_j || to_hit)    armed <= 1'b0;
    end
  end

  logic [NUM_DET-1:0] det_set, det_q;
  always_comb begin
    det_set           = '0;
    det_set[B_RESET]  = rst_hit;
    det_set[B_SUSP]   = susp_hit;
    det_set[B_RESUME] = res_pulse;
    det_set[B_TOUT]   = to_hit;
  end

  usbmon_sticky #(.N(NUM_DET)) u_sticky (
    .clk(clk), .rst_n(rst_n), .set(det_set), .clr(clr_w1c),
    .q(det_q), .evt(bus_event));

  logic [STATUS_W-1:NUM_DET] ctl_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else begin
      ctl_q          <= '0;
      ctl_q[B_PHY]   <= phy_en;
      ctl_q[B_RWAKE] <= rwake;
      ctl_q[B_CEN]   <= ctrl_en;
      ctl_q[B_PULL]  <= pullup_en;
    end
  end

  assign status   = {ctl_q, det_q};
  assign phy_en_o = phy_en;
  assign pullup_o = pullup_en;

  usbmon_drv u_drv (
    .rwake(rwake), .force_se0(force_se0),
    .bus_oe(bus_oe), .dp_drv(dp_drv), .dm_drv(dm_drv));

  // R3: resume only follows a suspend state
  assert_resume_needs_suspend_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_pulse |-> $past(suspended));

  // R8: disabled controller leaves no armed watch or pending resume
  assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ctrl_en) |-> (!armed && !res_pulse && !suspended));

  // R1: detected reset ends suspend
  assert_reset_ends_suspend_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_hit && ctrl_en) |=> !suspended);
endmodule

// File: tb/sim_usbmon_top.sv
`timescale 1ns/1ps
module sim_usbmon_top;
  localparam int CPU = 4;
  localparam int RST_LIM = (5 * CPU) / 2;   // 10
  localparam int SUSP_LIM = 3000 * CPU;     // 12000
  localparam int TO_LIM = (3 * CPU) / 2;    // 6
  localparam logic [1:0] SE0 = 2'b00, JJ = 2'b01, KK = 2'b10, SE1 = 2'b11;

  logic clk = 0, rst_n = 0;
  logic [1:0] line_state = JJ;
  logic tx_done = 0, ctrl_en = 0, phy_en = 0, rwake = 0, force_se0 = 0, pullup_en = 0;
  logic [3:0] clr_w1c = 0;
  logic [8:0] status;
  logic bus_event, bus_oe, dp_drv, dm_drv, phy_en_o, pullup_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  usbmon_top #(.CYC_PER_US(CPU)) u0 (
    .clk(clk), .rst_n(rst_n), .line_state(line_state), .tx_done(tx_done),
    .ctrl_en(ctrl_en), .phy_en(phy_en), .rwake(rwake), .force_se0(force_se0),
    .pullup_en(pullup_en), .clr_w1c(clr_w1c), .status(status), .bus_event(bus_event),
    .bus_oe(bus_oe), .dp_drv(dp_drv), .dm_drv(dm_drv), .phy_en_o(phy_en_o),
    .pullup_o(pullup_o));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    line_state = KK;
    clr_w1c = 4'hF;
    tick(1);
    clr_w1c = 4'h0;
    tick(1);
  endtask

  // {line[13:12], cycles[11:4], expected status[3:0]}
  localparam int NV = 6;
  localparam logic [13:0] VEC [NV] = '{
    {SE0, 8'(RST_LIM + 1), 4'b0000},
    {SE0, 8'(RST_LIM + 2), 4'b0001},
    {KK,  8'd50,           4'b0000},
    {SE0, 8'd5,            4'b0000},
    {SE1, 8'd40,           4'b0000},
    {SE0, 8'd60,           4'b0001}
  };

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    check("R6 reset status", 32'(status), 32'h0);
    check("R7 reset event", 32'(bus_event), 32'h0);
    ctrl_en = 1;
    tick(1);

    for (int i = 0; i < NV; i++) begin
      settle();
      line_state = VEC[i][13:12];
      tick(int'(VEC[i][11:4]));
      check($sformatf("R1 vector %0d", i), 32'(status[3:0]), 32'(VEC[i][3:0]));
    end

    // R1 / R7 event pulse at the exact cycle
    settle();
    line_state = SE0;
    tick(RST_LIM + 2);
    check("R7 event with reset", 32'(bus_event), 32'h1);
    tick(1);
    check("R7 event single", 32'(bus_event), 32'h0);

    // R2 suspend boundary
    settle();
    line_state = JJ;
    tick(SUSP_LIM + 1);
    check("R2 suspend early", 32'(status[1]), 32'h0);
    tick(1);
    check("R2 suspend set", 32'(status[1]), 32'h1);
    check("R7 event with suspend", 32'(bus_event), 32'h1);

    // R3 resume
    line_state = KK;
    tick(1);
    check("R3 resume not yet", 32'(status[2]), 32'h0);
    tick(1);
    check("R3 resume set", 32'(status[2]), 32'h1);
    // R3: K again, not suspended -> no new resume
    clr_w1c = 4'b0100;
    tick(1);
    clr_w1c = 0;
    tick(3);
    check("R3 no resume outside suspend", 32'(status[2]), 32'h0);

    // R1: reset ends suspend, later K gives no resume
    settle();
    line_state = JJ;
    tick(SUSP_LIM + 2);
    check("R2 suspend again", 32'(status[1]), 32'h1);
    line_state = SE0;
    tick(RST_LIM + 2);
    check("R1 reset in suspend", 32'(status[0]), 32'h1);
    line_state = KK;
    tick(3);
    check("R1 no resume after reset", 32'(status[2]), 32'h0);

    // R4 time-out boundary
    settle();
    line_state = JJ;
    tx_done = 1;
    tick(1);
    tx_done = 0;
    tick(TO_LIM + 1);
    check("R4 timeout early", 32'(status[3]), 32'h0);
    tick(1);
    check("R4 timeout set", 32'(status[3]), 32'h1);

    // R4 cancel by activity
    settle();
    line_state = JJ;
    tx_done = 1;
    tick(1);
    tx_done = 0;
    tick(3);
    line_state = KK;
    tick(1);
    line_state = JJ;
    tick(20);
    check("R4 timeout cancelled", 32'(status[3]), 32'h0);

    // R8 disable holds counters
    settle();
    ctrl_en = 0;
    line_state = SE0;
    tick(40);
    check("R8 no reset when off", 32'(status[0]), 32'h0);
    ctrl_en = 1;
    tick(RST_LIM + 1);
    check("R8 restart early", 32'(status[0]), 32'h0);
    tick(1);
    check("R8 restart full", 32'(status[0]), 32'h1);

    // R6 selective clear
    line_state = JJ;
    tx_done = 1;
    tick(1);
    tx_done = 0;
    tick(TO_LIM + 2);
    check("R6 two bits set", 32'(status[3:0]), 32'h9);
    clr_w1c = 4'b0001;
    tick(1);
    clr_w1c = 0;
    check("R6 clear only bit0", 32'(status[3:0]), 32'h8);

    // R5 drive
    rwake = 1;
    #1;
    check("R5 K drive", 32'({bus_oe, dp_drv, dm_drv}), 32'b101);
    force_se0 = 1;
    #1;
    check("R5 SE0 priority", 32'({bus_oe, dp_drv, dm_drv}), 32'b100);
    rwake = 0;
    #1;
    check("R5 SE0 drive", 32'({bus_oe, dp_drv, dm_drv}), 32'b100);
    force_se0 = 0;
    #1;
    check("R5 release", 32'(bus_oe), 32'h0);

    // R9 pass-through
    tick(1);
    phy_en = 1; pullup_en = 1; rwake = 1;
    #1;
    check("R9 direct outs", 32'({phy_en_o, pullup_o}), 32'b11);
    tick(1);
    check("R9 status ctl bits", 32'(status[8:4]), 32'b11011);
    ctrl_en = 0; rwake = 0;
    tick(1);
    check("R9 status ctl off", 32'(status[8:4]), 32'b10001);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule